// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block carries out the architectural bookkeeping that a 64-bit register-windowed processor performs when it takes a trap. The pipeline supplies the trap type together with a snapshot of the current state: program counter and its successor, condition codes, address space identifier, processor state word, window pointer, spare-window count, trap level and trap base address. From these the block works out the new trap level and the new processor state word, with its global register set and its reset-error flag. It also works out the adjusted window pointer and the trap vector address, and it saves the pre-trap context into a small stack that has one entry per trap level.

A trap is requested by a one-cycle `trap_valid` pulse. All updates are registered on that clock edge. On the next cycle `done` pulses and the `new_*` outputs carry the state that the pipeline must adopt. A trap that arrives when the trap level is already at its ceiling changes nothing and is reported through `err_state`. The saved context of any level can be read back combinationally through the read port.

Top module: `trap_entry_seq`

## Requirements
- R1: `done` is high in the cycle after each cycle in which `trap_valid` is high, and low in every other cycle.
- R2: When `cur_tl >= MAXTL` (5 by default), the trap raises `err_state` together with `done`. The `new_*` outputs then equal the current inputs (`cur_tl`, `cur_pstate`, `cur_cwp`, `cur_pc`, `cur_npc`), and no stack entry is written.
- R3: When `cur_tl < MAXTL-1`, `new_tl` is `cur_tl+1` and the reset-error flag (PSTATE bit 5) is passed through unchanged. When `cur_tl == MAXTL-1`, `new_tl` is `MAXTL` and PSTATE bit 5 is set.
- R4: The saved TSTATE, which is 40 bits wide, holds CCR in bits 39:32 and ASI in bits 31:24. Bits 19:8 hold the pre-trap PSTATE, including any bit 5 set by R3, masked with 0xF3F. Bits CWPW-1:0 hold CWP. All other bits are zero.
- R5: The stack entry at index `new_tl` receives TSTATE, `cur_pc`, `cur_npc` and the trap type. `rd_tstate`, `rd_tpc`, `rd_tnpc` and `rd_tt` show the entry selected by `rd_level`.
- R6: The PSTATE bits are PEF=4, PRIV=2, alternate globals=0, MMU globals=10 and interrupt globals=11. After a trap, PEF and PRIV are set and exactly one global-select bit is set. Interrupt globals are chosen for type 0x060. MMU globals are chosen for types 0x008 and 0x030 and for the ranges 0x064-0x067, 0x068-0x06B and 0x06C-0x06F. Alternate globals are chosen for every other type. All other PSTATE bits keep their value.
- R7: A clean-window trap (type 0x024) sets `new_cwp` to (CWP-1) mod NWINDOWS.
- R8: A spill trap (type bits 8:6 = 3'b010) sets `new_cwp` to (CWP-CANSAVE-2) mod NWINDOWS. A fill trap (type bits 8:6 = 3'b011) sets it to (CWP+1) mod NWINDOWS. Any other type leaves CWP unchanged.
- R9: `new_pc` equals `tba` with bits 14:0 replaced as follows: bit 14 is set when `new_tl > 1`, bits 13:5 hold the trap type, and bits 4:0 are zero. `new_npc` equals `new_pc + 4`.
- R10: After reset, `done`, `err_state` and every `new_*` output are zero, and every stack entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | One-cycle trap request |
| trap_type | input | 9 | Trap type code |
| cur_pc | input | 64 | Current program counter |
| cur_npc | input | 64 | Current next program counter |
| cur_ccr | input | 8 | Condition codes |
| cur_asi | input | 8 | Current address space identifier |
| cur_pstate | input | 12 | Current processor state word |
| cur_cwp | input | CWPW | Current window pointer |
| cur_cansave | input | CWPW | Windows available for save |
| cur_tl | input | TLW | Current trap level |
| tba | input | 64 | Trap base address |
| done | output | 1 | Trap processed pulse |
| err_state | output | 1 | Trap arrived at the trap-level ceiling |
| new_tl | output | TLW | Trap level after the trap |
| new_pstate | output | 12 | Processor state word after the trap |
| new_cwp | output | CWPW | Window pointer after the trap |
| new_pc | output | 64 | Trap vector address |
| new_npc | output | 64 | Trap vector plus 4 |
| rd_level | input | TLW | Stack read index |
| rd_tstate | output | 40 | Saved TSTATE at `rd_level` |
| rd_tpc | output | 64 | Saved PC at `rd_level` |
| rd_tnpc | output | 64 | Saved next PC at `rd_level` |
| rd_tt | output | 9 | Saved trap type at `rd_level` |

## Verification
The assertions check on every cycle that the done pulse follows the request and that the error case holds the trap level and PC. They also check the level increment with its reset-error flag at the last level, that PEF and PRIV are set and exactly one global select is chosen, the vector fields and NPC offset, and the fill-trap window step. The bench's scenarios are needed for the behaviours that depend on stored state: the exact TSTATE packing and the saved PC, NPC and type read back from the stack, and the absence of any stack write on an error trap. They are also needed to confirm, value by value, that each trap class picks the right global set and that spill and clean-window arithmetic wraps correctly.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int PSW = 12;
    localparam int TSW = 40;

    // processor state word bit positions
    localparam int PS_AG   = 0;
    localparam int PS_PRIV = 2;
    localparam int PS_PEF  = 4;
    localparam int PS_RED  = 5;
    localparam int PS_MG   = 10;
    localparam int PS_IG   = 11;

    localparam logic [PSW-1:0] SAVE_MASK = 12'hF3F;
    localparam logic [PSW-1:0] GSEL_MASK = PSW'((1 << PS_AG) | (1 << PS_MG) | (1 << PS_IG));

    typedef logic [8:0] ttype_t;

    localparam ttype_t TT_INSN_FAULT = 9'h008;
    localparam ttype_t TT_WIN_CLEAN  = 9'h024;
    localparam ttype_t TT_DATA_FAULT = 9'h030;
    localparam ttype_t TT_INT_VECTOR = 9'h060;
    localparam ttype_t TT_IMISS_BASE = 9'h064;
    localparam ttype_t TT_DMISS_BASE = 9'h068;
    localparam ttype_t TT_DPROT_BASE = 9'h06C;
    localparam logic [2:0] CLASS_SPILL = 3'b010;
    localparam logic [2:0] CLASS_FILL  = 3'b011;

    typedef enum logic [1:0] {GSEL_ALT, GSEL_MMU, GSEL_INT} gsel_e;
    typedef enum logic [1:0] {WADJ_NONE, WADJ_CLEAN, WADJ_SPILL, WADJ_FILL} wadj_e;

    typedef struct packed {
        logic [TSW-1:0] tstate;
        logic [63:0]    tpc;
        logic [63:0]    tnpc;
        ttype_t         tt;
    } tsave_t;

    function automatic gsel_e pick_globals(ttype_t tt);
        if (tt == TT_INT_VECTOR)
            return GSEL_INT;
        if (tt == TT_INSN_FAULT || tt == TT_DATA_FAULT ||
            tt[8:2] == TT_IMISS_BASE[8:2] || tt[8:2] == TT_DMISS_BASE[8:2] ||
            tt[8:2] == TT_DPROT_BASE[8:2])
            return GSEL_MMU;
        return GSEL_ALT;
    endfunction

    function automatic wadj_e pick_window(ttype_t tt);
        if (tt == TT_WIN_CLEAN)       return WADJ_CLEAN;
        if (tt[8:6] == CLASS_SPILL)   return WADJ_SPILL;
        if (tt[8:6] == CLASS_FILL)    return WADJ_FILL;
        return WADJ_NONE;
    endfunction

    function automatic logic [PSW-1:0] gsel_bits(gsel_e g);
        logic [PSW-1:0] b;
        b = '0;
        case (g)
            GSEL_INT: b[PS_IG] = 1'b1;
            GSEL_MMU: b[PS_MG] = 1'b1;
            default:  b[PS_AG] = 1'b1;
        endcase
        return b;
    endfunction

    function automatic logic [TSW-1:0] pack_tstate(logic [7:0] ccr, logic [7:0] asi,
                                                   logic [PSW-1:0] ps, logic [7:0] cwp8);
        return {ccr, asi, 4'b0000, ps & SAVE_MASK, cwp8};
    endfunction

endpackage

// File: rtl/trap_level_ctl.sv
module trap_level_ctl #(
    parameter int MAXTL = 5,
    parameter int TLW   = 3
) (
    input  logic [TLW-1:0] cur_tl,
    output logic           level_err,
    output logic           red_set,
    output logic [TLW-1:0] tl_next
);
    always_comb begin
        level_err = (int'(cur_tl) >= MAXTL);
        red_set   = 1'b0;
        tl_next   = cur_tl;
        if (!level_err) begin
            tl_next = cur_tl + TLW'(1);
            red_set = (int'(cur_tl) >= MAXTL - 1);
        end
    end
endmodule

// File: rtl/trap_window_adj.sv
module trap_window_adj import trap_entry_pkg::*; #(
    parameter int NWINDOWS = 8,
    parameter int CWPW     = 3
) (
    input  wadj_e           mode,
    input  logic [CWPW-1:0] cwp,
    input  logic [CWPW-1:0] cansave,
    output logic [CWPW-1:0] cwp_out
);
    int res;

    always_comb begin
        case (mode)
            WADJ_CLEAN: res = (int'(cwp) + NWINDOWS - 1) % NWINDOWS;
            WADJ_SPILL: res = (int'(cwp) + 2 * NWINDOWS - int'(cansave) - 2) % NWINDOWS;
            WADJ_FILL:  res = (int'(cwp) + 1) % NWINDOWS;
            default:    res = int'(cwp);
        endcase
        cwp_out = res[CWPW-1:0];
    end
endmodule

// File: rtl/trap_state_stack.sv
module trap_state_stack import trap_entry_pkg::*; #(
    parameter int TLW = 3,
    localparam int DEPTH = 1 << TLW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [TLW-1:0] waddr,
    input  tsave_t         wdata,
    input  logic [TLW-1:0] raddr,
    output tsave_t         rdata
);
    tsave_t entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry_q[g] <= '0;
            else if (we && waddr == TLW'(g))
                entry_q[g] <= wdata;
        end
    end

    assign rdata = entry_q[raddr];
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq import trap_entry_pkg::*; #(
    parameter int NWINDOWS = 8,
    parameter int MAXTL    = 5,
    localparam int CWPW    = (NWINDOWS > 1) ? $clog2(NWINDOWS) : 1,
    localparam int TLW     = $clog2(MAXTL + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_valid,
    input  logic [8:0]      trap_type,
    input  logic [63:0]     cur_pc,
    input  logic [63:0]     cur_npc,
    input  logic [7:0]      cur_ccr,
    input  logic [7:0]      cur_asi,
    input  logic [11:0]     cur_pstate,
    input  logic [CWPW-1:0] cur_cwp,
    input  logic [CWPW-1:0] cur_cansave,
    input  logic [TLW-1:0]  cur_tl,
    input  logic [63:0]     tba,
    output logic            done,
    output logic            err_state,
    output logic [TLW-1:0]  new_tl,
    output logic [11:0]     new_pstate,
    output logic [CWPW-1:0] new_cwp,
    output logic [63:0]     new_pc,
    output logic [63:0]     new_npc,
    input  logic [TLW-1:0]  rd_level,
    output logic [39:0]     rd_tstate,
    output logic [63:0]     rd_tpc,
    output logic [63:0]     rd_tnpc,
    output logic [8:0]      rd_tt
);
    logic           level_err;
    logic           red_set;
    logic [TLW-1:0] tl_next;
    logic [CWPW-1:0] cwp_next;
    gsel_e          gsel;
    wadj_e          wmode;
    logic [PSW-1:0] ps_red;
    logic [PSW-1:0] ps_next;
    logic [63:0]    vec_pc;
    tsave_t         save_w;
    tsave_t         save_r;

    trap_level_ctl #(.MAXTL(MAXTL), .TLW(TLW)) level_i (
        .cur_tl   (cur_tl),
        .level_err(level_err),
        .red_set  (red_set),
        .tl_next  (tl_next)
    );

    assign wmode = pick_window(trap_type);
    assign gsel  = pick_globals(trap_type);

    trap_window_adj #(.NWINDOWS(NWINDOWS), .CWPW(CWPW)) window_i (
        .mode   (wmode),
        .cwp    (cur_cwp),
        .cansave(cur_cansave),
        .cwp_out(cwp_next)
    );

    always_comb begin
        ps_red = cur_pstate;
        if (red_set)
            ps_red[PS_RED] = 1'b1;
        ps_next = (ps_red & ~GSEL_MASK) | gsel_bits(gsel);
        ps_next[PS_PEF]  = 1'b1;
        ps_next[PS_PRIV] = 1'b1;
        vec_pc = {tba[63:15], (int'(tl_next) > 1), trap_type, 5'b00000};
        save_w.tstate = pack_tstate(cur_ccr, cur_asi, ps_red, 8'(cur_cwp));
        save_w.tpc    = cur_pc;
        save_w.tnpc   = cur_npc;
        save_w.tt     = trap_type;
    end

    trap_state_stack #(.TLW(TLW)) stack_i (
        .clk  (clk),
        .rst  (rst),
        .we   (trap_valid && !level_err),
        .waddr(tl_next),
        .wdata(save_w),
        .raddr(rd_level),
        .rdata(save_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            err_state  <= 1'b0;
            new_tl     <= '0;
            new_pstate <= '0;
            new_cwp    <= '0;
            new_pc     <= '0;
            new_npc    <= '0;
        end else begin
            done <= trap_valid;
            if (trap_valid) begin
                err_state <= level_err;
                if (level_err) begin
                    new_tl     <= cur_tl;
                    new_pstate <= cur_pstate;
                    new_cwp    <= cur_cwp;
                    new_pc     <= cur_pc;
                    new_npc    <= cur_npc;
                end else begin
                    new_tl     <= tl_next;
                    new_pstate <= ps_next;
                    new_cwp    <= cwp_next;
                    new_pc     <= vec_pc;
                    new_npc    <= vec_pc + 64'd4;
                end
            end
        end
    end

    assign rd_tstate = save_r.tstate;
    assign rd_tpc    = save_r.tpc;
    assign rd_tnpc   = save_r.tnpc;
    assign rd_tt     = save_r.tt;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int NWINDOWS = 8,
    parameter int MAXTL    = 5,
    localparam int CWPW    = (NWINDOWS > 1) ? $clog2(NWINDOWS) : 1,
    localparam int TLW     = $clog2(MAXTL + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            trap_valid,
    input logic [8:0]      trap_type,
    input logic [63:0]     cur_pc,
    input logic [CWPW-1:0] cur_cwp,
    input logic [TLW-1:0]  cur_tl,
    input logic [63:0]     tba,
    input logic            done,
    input logic            err_state,
    input logic [TLW-1:0]  new_tl,
    input logic [11:0]     new_pstate,
    input logic [CWPW-1:0] new_cwp,
    input logic [63:0]     new_pc,
    input logic [63:0]     new_npc
);
    assert_done_follows_R1: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> done);

    assert_done_only_on_req_R1: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |=> !done);

    assert_err_holds_state_R2: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && int'(cur_tl) >= MAXTL) |=>
            (err_state && new_tl == $past(cur_tl) && new_pc == $past(cur_pc)));

    assert_tl_increments_R3: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && int'(cur_tl) < MAXTL) |=>
            (!err_state && int'(new_tl) == int'($past(cur_tl)) + 1));

    assert_red_at_last_level_R3: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && int'(cur_tl) == MAXTL - 1) |=> new_pstate[5]);

    assert_priv_and_one_global_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !err_state) |->
            (new_pstate[4] && new_pstate[2] &&
             $countones({new_pstate[11], new_pstate[10], new_pstate[0]}) == 1));

    assert_fill_window_step_R8: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && int'(cur_tl) < MAXTL && trap_type[8:6] == 3'b011) |=>
            (int'(new_cwp) == (int'($past(cur_cwp)) + 1) % NWINDOWS));

    assert_vector_npc_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !err_state) |-> (new_npc == new_pc + 64'd4 && new_pc[4:0] == 5'd0));

    assert_vector_fields_R9: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && int'(cur_tl) < MAXTL) |=>
            (new_pc[13:5] == $past(trap_type) && new_pc[63:15] == $past(tba[63:15])));
endmodule

bind trap_entry_seq trap_entry_chk #(.NWINDOWS(NWINDOWS), .MAXTL(MAXTL)) chk_i (.*);

// File: tb/trap_entry_seq_tb_top.sv
`timescale 1ns/1ps
module trap_entry_seq_tb_top;
    localparam int NW   = 8;
    localparam int MTL  = 5;
    localparam int CW   = 3;
    localparam int TW   = 3;
    localparam int NLEV = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trap_valid = 1'b0;
    logic [8:0]    trap_type = '0;
    logic [63:0]   cur_pc = '0, cur_npc = '0, tba = '0;
    logic [7:0]    cur_ccr = '0, cur_asi = '0;
    logic [11:0]   cur_pstate = '0;
    logic [CW-1:0] cur_cwp = '0, cur_cansave = '0;
    logic [TW-1:0] cur_tl = '0, rd_level = '0;
    logic          done, err_state;
    logic [TW-1:0] new_tl;
    logic [11:0]   new_pstate;
    logic [CW-1:0] new_cwp;
    logic [63:0]   new_pc, new_npc, rd_tpc, rd_tnpc;
    logic [39:0]   rd_tstate;
    logic [8:0]    rd_tt;

    int checks = 0;
    int fails  = 0;

    // bench model of the save stack
    logic [39:0] m_ts  [NLEV];
    logic [63:0] m_pc  [NLEV];
    logic [63:0] m_npc [NLEV];
    logic [8:0]  m_tt  [NLEV];

    trap_entry_seq #(.NWINDOWS(NW), .MAXTL(MTL)) dut_i (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_type(trap_type),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
        .cur_pstate(cur_pstate), .cur_cwp(cur_cwp), .cur_cansave(cur_cansave),
        .cur_tl(cur_tl), .tba(tba), .done(done), .err_state(err_state),
        .new_tl(new_tl), .new_pstate(new_pstate), .new_cwp(new_cwp),
        .new_pc(new_pc), .new_npc(new_npc), .rd_level(rd_level),
        .rd_tstate(rd_tstate), .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc), .rd_tt(rd_tt)
    );

    always #2 clk = ~clk;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int exp_cwp(logic [8:0] tt, int cwp, int cs);
        if (tt == 9'h024)          return (cwp + NW - 1) % NW;       // R7
        if (tt[8:6] == 3'b010)     return (cwp + 2 * NW - cs - 2) % NW; // R8 spill
        if (tt[8:6] == 3'b011)     return (cwp + 1) % NW;            // R8 fill
        return cwp;
    endfunction

    function automatic logic [11:0] exp_ps(logic [8:0] tt, logic [11:0] ps);
        logic [11:0] r;
        r = ps & ~12'hC01;
        r[4] = 1'b1;
        r[2] = 1'b1;
        if (tt == 9'h060) r[11] = 1'b1;
        else if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F)) r[10] = 1'b1;
        else r[0] = 1'b1;
        return r;
    endfunction

    task automatic check_level(int lv, string req);
        rd_level = TW'(lv);
        #0.5;
        chk({req, " tstate"}, 64'(rd_tstate), 64'(m_ts[lv]));
        chk({req, " tpc"},    rd_tpc,          m_pc[lv]);
        chk({req, " tnpc"},   rd_tnpc,         m_npc[lv]);
        chk({req, " tt"},     64'(rd_tt),      64'(m_tt[lv]));
    endtask

    task automatic do_trap(logic [8:0] tt, int tl, int cwp, int cs, logic [11:0] ps);
        logic [11:0] ps_r;
        logic [63:0] vec;
        int ntl;
        logic ferr;
        @(negedge clk);
        trap_type = tt; cur_tl = TW'(tl); cur_cwp = CW'(cwp); cur_cansave = CW'(cs);
        cur_pstate = ps;
        cur_pc = {$urandom, $urandom}; cur_npc = {$urandom, $urandom};
        cur_ccr = 8'($urandom); cur_asi = 8'($urandom); tba = {$urandom, $urandom};
        trap_valid = 1'b1;
        @(negedge clk);
        trap_valid = 1'b0;
        ferr = (tl >= MTL);
        chk("R1 done", 64'(done), 64'd1);
        chk("R2 err_state", 64'(err_state), 64'(ferr));
        if (ferr) begin
            chk("R2 tl held", 64'(new_tl), 64'(tl));
            chk("R2 pstate held", 64'(new_pstate), 64'(ps));
            chk("R2 cwp held", 64'(new_cwp), 64'(cwp));
            chk("R2 pc held", new_pc, cur_pc);
            chk("R2 npc held", new_npc, cur_npc);
            for (int i = 0; i < NLEV; i++) check_level(i, "R2 stack untouched");
        end else begin
            ntl  = tl + 1;
            ps_r = ps;
            if (tl == MTL - 1) ps_r[5] = 1'b1;
            vec = {tba[63:15], ntl > 1, tt, 5'd0};
            chk("R3 new_tl", 64'(new_tl), 64'(ntl));
            chk("R3/R6 new_pstate", 64'(new_pstate), 64'(exp_ps(tt, ps_r)));
            chk("R7/R8 new_cwp", 64'(new_cwp), 64'(exp_cwp(tt, cwp, cs)));
            chk("R9 new_pc", new_pc, vec);
            chk("R9 new_npc", new_npc, vec + 64'd4);
            m_ts[ntl]  = {cur_ccr, cur_asi, 4'd0, ps_r & 12'hF3F, 5'd0, CW'(cwp)};
            m_pc[ntl]  = cur_pc;
            m_npc[ntl] = cur_npc;
            m_tt[ntl]  = tt;
            check_level(ntl, "R4/R5 saved entry");
        end
        @(negedge clk);
        chk("R1 done low", 64'(done), 64'd0);
    endtask

    function automatic logic [8:0] pick_type();
        case ($urandom % 8)
            0: return 9'h060;
            1: return ($urandom % 2) ? 9'h008 : 9'h030;
            2: return 9'h064 + 9'($urandom % 4);
            3: return (($urandom % 2) ? 9'h068 : 9'h06C) + 9'($urandom % 4);
            4: return 9'h024;
            5: return 9'h080 | 9'($urandom % 64);
            6: return 9'h0C0 | 9'($urandom % 64);
            default: return 9'($urandom);
        endcase
    endfunction

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NLEV; i++) begin
            m_ts[i] = '0; m_pc[i] = '0; m_npc[i] = '0; m_tt[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 done", 64'(done), 64'd0);
        chk("R10 err_state", 64'(err_state), 64'd0);
        chk("R10 new_tl", 64'(new_tl), 64'd0);
        chk("R10 new_pc", new_pc, 64'd0);
        check_level(0, "R10 stack");
        check_level(5, "R10 stack");

        // directed corners
        do_trap(9'h060, 0, 3, 2, 12'h000);   // R6 interrupt globals, R9 bit14 clear
        do_trap(9'h066, 1, 0, 5, 12'hFFF);   // R6 MMU range, R9 bit14 set
        do_trap(9'h024, 2, 0, 0, 12'h0C0);   // R7 wrap to 7
        do_trap(9'h0A5, 3, 1, 7, 12'h123);   // R8 spill wrap
        do_trap(9'h0C3, 0, 7, 0, 12'h400);   // R8 fill wrap to 0
        do_trap(9'h041, 4, 4, 1, 12'h000);   // R3 last level sets RED
        do_trap(9'h008, 5, 2, 1, 12'h055);   // R2 ceiling
        do_trap(9'h030, 7, 6, 3, 12'hABC);   // R2 above ceiling
        do_trap(9'h06F, 1, 5, 2, 12'h020);   // R3 RED passes through

        for (int n = 0; n < 400; n++) begin
            int tl;
            tl = ($urandom % 12 == 0) ? 6 + int'($urandom % 2) : int'($urandom % (MTL + 1));
            do_trap(pick_type(), tl, int'($urandom % NW), int'($urandom % NW), 12'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule